// File: doc/BRIEF.md
# Packed 52-bit Multiply-Shift-Accumulate Unit

This block is a pipelined SIMD datapath for wide-integer arithmetic that stores numbers in radix 2^52. Each operand vector is 512 bits wide and holds eight independent 64-bit lanes. In every lane the unit multiplies the two 52-bit digits held in the low bits of the multiplicand lanes, which gives a 104-bit product. It then adds a chosen part of that product to the 64-bit accumulator lane. The low half, the high half, or the high half shifted left by an immediate amount can be chosen. The shifted form folds the doubling step of a squaring loop into one operation.

Operations enter and leave through valid/ready streams. One operation is accepted on each rising edge where `in_valid` and `in_ready` are both high. Its result is presented four register stages later. A result is consumed on each rising edge where `out_valid` and `out_ready` are both high. When the consumer holds `out_ready` low while a result is waiting, the whole pipeline freezes. While it is frozen, `in_ready` is low and the waiting result, including `out_valid`, stays unchanged. A producer must keep its operands steady while `in_valid` is high and `in_ready` is low. `mode_i` and `shamt_i` travel with the operands of their operation.

Top module: `msa_unit`

## Requirements
- R1: After reset is released, `out_valid` is low and `in_ready` is high.
- R2: Lane j occupies bits [64j+63:64j] of every vector. Each lane's 64-bit sum wraps modulo 2^64, and no carry passes into a neighbouring lane.
- R3: Only bits [51:0] of each lane of `mul_a_i` and `mul_b_i` enter the multiplier. Bits [63:52] of those lanes have no effect on any result.
- R4: With `mode_i` = 2'b00, the lane result is the accumulator lane plus product bits [51:0], zero-extended to 64 bits.
- R5: With `mode_i` = 2'b01, the lane result is the accumulator lane plus product bits [103:52], zero-extended to 64 bits.
- R6: With `mode_i` = 2'b10, product bits [103:52] are zero-extended to 64 bits and shifted left by `shamt_i`, and the shifted value is added to the accumulator lane.
- R7: In shifted mode with `shamt_i` = 0, the result equals the high-half result for the same operands.
- R8: In shifted mode, bits moved beyond bit 63 are discarded. A `shamt_i` of 64 or more gives a zero addend, so the result equals the accumulator lane.
- R9: An operation accepted at rising edge n, with `out_ready` held high, is presented with `out_valid` high right after rising edge n+3. No more than four operations are in flight.
- R10: While `out_ready` stays high, `in_ready` stays high, and one operation can be accepted on every cycle.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and on the next cycle `out_valid` is still high and `res_o` is unchanged. Results leave in the order in which their operations were accepted, and none is lost or duplicated.
- R12: `mode_i` = 2'b11 behaves exactly as 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit takes the offered operation on this edge |
| acc_i | input | 512 | Eight 64-bit accumulator lanes |
| mul_a_i | input | 512 | Eight multiplicand lanes; bits [51:0] of each lane are used |
| mul_b_i | input | 512 | Eight multiplier lanes; bits [51:0] of each lane are used |
| mode_i | input | 2 | 00 low half, 01 high half, 1x shifted high half |
| shamt_i | input | 8 | Left-shift amount applied in shifted mode |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the presented result on this edge |
| res_o | output | 512 | Eight 64-bit result lanes |

## Verification
On every cycle, the assertions check the flow control. The number of stage valid bits must equal the number of operations accepted minus the number delivered, and it can never exceed four. A result that is waiting must keep its valid flag and its data while it is stalled. In the low and high modes, the selected addend must have its upper twelve bits at zero. The arithmetic itself can only be shown by the bench's scenarios. Those scenarios check the low, high and shifted selections against the bench's own 128-bit arithmetic, as well as wrap-around, ignored upper operand bits, shifts of zero and of 64 or more, mode 3, exact latency at full rate, and ordering under random back-pressure.

// File: rtl/msa_pkg.sv
package msa_pkg;

  // Default geometry of the unit
  localparam int unsigned MSA_LANES  = 8;
  localparam int unsigned MSA_LANE_W = 64;
  localparam int unsigned MSA_MUL_W  = 52;
  localparam int unsigned MSA_SH_W   = 8;
  localparam int unsigned MSA_STAGES = 4;

  // Accumulation selection
  typedef enum logic [1:0] {
    MSA_LO      = 2'b00,
    MSA_HI      = 2'b01,
    MSA_SHL     = 2'b10,
    MSA_SHL_ALT = 2'b11
  } msa_mode_e;

endpackage

// File: rtl/msa_ctrl.sv
module msa_ctrl #(
  parameter int unsigned STAGES = msa_pkg::MSA_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              adv,
  output logic [STAGES-1:0] stage_v,
  output logic              out_valid
);

  localparam int unsigned CNT_W = $clog2(STAGES + 1) + 1;

  logic [STAGES-1:0] vld_q;

  // The pipe moves unless a finished result is waiting on the consumer
  assign adv       = !vld_q[STAGES-1] || out_ready;
  assign in_ready  = adv;
  assign out_valid = vld_q[STAGES-1];
  assign stage_v   = vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (adv) begin
      vld_q <= {vld_q[STAGES-2:0], in_valid};
    end
  end

  // Token bookkeeping used only by the checks below
  logic [CNT_W-1:0] tok_q;
  logic             take, give;
  assign take = in_valid && in_ready;
  assign give = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
    end else begin
      tok_q <= tok_q + CNT_W'(take) - CNT_W'(give);
    end
  end

  // R9
  tokens_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_q <= CNT_W'(STAGES)) && ($countones(vld_q) == int'(tok_q)));

  // R11
  no_phantom_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (tok_q != '0));

  // R11
  stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

endmodule

// File: rtl/msa_addend.sv
module msa_addend #(
  parameter int unsigned LANE_W = msa_pkg::MSA_LANE_W,
  parameter int unsigned MUL_W  = msa_pkg::MSA_MUL_W,
  parameter int unsigned SH_W   = msa_pkg::MSA_SH_W
) (
  input  logic [2*MUL_W-1:0]      prod,
  input  msa_pkg::msa_mode_e      mode,
  input  logic [SH_W-1:0]         shamt,
  output logic [LANE_W-1:0]       addend
);

  localparam int unsigned PAD_W = LANE_W - MUL_W;

  logic [LANE_W-1:0] lo_ext, hi_ext, hi_shl;

  assign lo_ext = {{PAD_W{1'b0}}, prod[MUL_W-1:0]};
  assign hi_ext = {{PAD_W{1'b0}}, prod[2*MUL_W-1:MUL_W]};
  // A shift of LANE_W or more leaves nothing
  assign hi_shl = hi_ext << shamt;

  always_comb begin
    unique case (mode)
      msa_pkg::MSA_LO: addend = lo_ext;
      msa_pkg::MSA_HI: addend = hi_ext;
      default:         addend = hi_shl;
    endcase
  end

endmodule

// File: rtl/msa_lane.sv
module msa_lane #(
  parameter int unsigned LANE_W = msa_pkg::MSA_LANE_W,
  parameter int unsigned MUL_W  = msa_pkg::MSA_MUL_W,
  parameter int unsigned SH_W   = msa_pkg::MSA_SH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               v3,
  input  logic [MUL_W-1:0]   a,
  input  logic [MUL_W-1:0]   b,
  input  logic [LANE_W-1:0]  acc,
  input  logic [1:0]         mode,
  input  logic [SH_W-1:0]    shamt,
  output logic [LANE_W-1:0]  res
);

  import msa_pkg::*;

  localparam int unsigned LO_W   = MUL_W / 2;
  localparam int unsigned HI_W   = MUL_W - LO_W;
  localparam int unsigned PP_W   = MUL_W + HI_W;
  localparam int unsigned PROD_W = 2 * MUL_W;

  // Stage 1: operand capture
  logic [MUL_W-1:0]  a1_q, b1_q;
  logic [LANE_W-1:0] acc1_q;
  msa_mode_e         mode1_q;
  logic [SH_W-1:0]   sh1_q;

  // Stage 2: two partial products over the split multiplier
  logic [PP_W-1:0]   pplo2_q, pphi2_q;
  logic [LANE_W-1:0] acc2_q;
  msa_mode_e         mode2_q;
  logic [SH_W-1:0]   sh2_q;

  // Stage 3: selected addend
  logic [LANE_W-1:0] add3_q, acc3_q;
  msa_mode_e         mode3_q;

  // Stage 4: result
  logic [LANE_W-1:0] res4_q;

  logic [PP_W-1:0]   pplo_d, pphi_d;
  logic [PROD_W-1:0] prod_d;
  logic [LANE_W-1:0] add_d;

  assign pplo_d = PP_W'(a1_q) * PP_W'(b1_q[LO_W-1:0]);
  assign pphi_d = PP_W'(a1_q) * PP_W'(b1_q[MUL_W-1:LO_W]);
  assign prod_d = PROD_W'(pplo2_q) + {pphi2_q, {LO_W{1'b0}}};

  msa_addend #(.LANE_W(LANE_W), .MUL_W(MUL_W), .SH_W(SH_W)) u_addend (
    .prod   (prod_d),
    .mode   (mode2_q),
    .shamt  (sh2_q),
    .addend (add_d)
  );

  always_ff @(posedge clk) begin
    if (adv) begin
      a1_q    <= a;
      b1_q    <= b;
      acc1_q  <= acc;
      mode1_q <= msa_mode_e'(mode);
      sh1_q   <= shamt;

      pplo2_q <= pplo_d;
      pphi2_q <= pphi_d;
      acc2_q  <= acc1_q;
      mode2_q <= mode1_q;
      sh2_q   <= sh1_q;

      add3_q  <= add_d;
      acc3_q  <= acc2_q;
      mode3_q <= mode2_q;

      res4_q  <= acc3_q + add3_q;
    end
  end

  assign res = res4_q;

  // R4 R5
  plain_half_zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v3 && !mode3_q[1]) |-> (add3_q[LANE_W-1:MUL_W] == '0));

endmodule

// File: rtl/msa_unit.sv
module msa_unit #(
  parameter int unsigned LANES  = msa_pkg::MSA_LANES,
  parameter int unsigned LANE_W = msa_pkg::MSA_LANE_W,
  parameter int unsigned MUL_W  = msa_pkg::MSA_MUL_W,
  parameter int unsigned SH_W   = msa_pkg::MSA_SH_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [LANES*LANE_W-1:0]  acc_i,
  input  logic [LANES*LANE_W-1:0]  mul_a_i,
  input  logic [LANES*LANE_W-1:0]  mul_b_i,
  input  logic [1:0]               mode_i,
  input  logic [SH_W-1:0]          shamt_i,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES*LANE_W-1:0]  res_o
);

  localparam int unsigned STAGES = msa_pkg::MSA_STAGES;

  logic              adv;
  logic [STAGES-1:0] stage_v;

  msa_ctrl #(.STAGES(STAGES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .adv       (adv),
    .stage_v   (stage_v),
    .out_valid (out_valid)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic unused_upper;
    assign unused_upper = ^{mul_a_i[l*LANE_W+MUL_W +: LANE_W-MUL_W],
                            mul_b_i[l*LANE_W+MUL_W +: LANE_W-MUL_W]};

    msa_lane #(.LANE_W(LANE_W), .MUL_W(MUL_W), .SH_W(SH_W)) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .v3    (stage_v[2]),
      .a     (mul_a_i[l*LANE_W +: MUL_W]),
      .b     (mul_b_i[l*LANE_W +: MUL_W]),
      .acc   (acc_i[l*LANE_W +: LANE_W]),
      .mode  (mode_i),
      .shamt (shamt_i),
      .res   (res_o[l*LANE_W +: LANE_W])
    );
  end

  // R11
  stall_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(res_o));

endmodule

// File: tb/msa_unit_bench.sv
module msa_unit_bench;

  localparam int VW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [VW-1:0] acc_i = '0, mul_a_i = '0, mul_b_i = '0;
  logic [1:0]    mode_i = 2'b00;
  logic [7:0]    shamt_i = 8'd0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [VW-1:0] res_o;

  always #10 clk = ~clk;

  msa_unit u_msa_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .acc_i(acc_i), .mul_a_i(mul_a_i), .mul_b_i(mul_b_i), .mode_i(mode_i),
    .shamt_i(shamt_i), .out_valid(out_valid), .out_ready(out_ready), .res_o(res_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 1'b0;
  bit lat_mode = 1'b0;
  bit full_rate = 1'b0;
  bit prev_stall = 1'b0;
  logic [VW-1:0] prev_res;

  logic [VW-1:0] exp_q[$];
  int            cyc_q[$];
  string         tag_q[$];

  function automatic logic [63:0] model_lane(logic [63:0] a, logic [63:0] b,
                                             logic [63:0] c, logic [1:0] m, logic [7:0] s);
    logic [127:0] p;
    logic [63:0]  hi, add;
    p  = {76'd0, a[51:0]} * {76'd0, b[51:0]};
    hi = {12'd0, p[103:52]};
    if (m == 2'b00)      add = {12'd0, p[51:0]};
    else if (m == 2'b01) add = hi;
    else if (s >= 8'd64) add = 64'd0;
    else                 add = hi << s;
    return c + add;
  endfunction

  function automatic logic [VW-1:0] model_vec(logic [VW-1:0] a, logic [VW-1:0] b,
                                              logic [VW-1:0] c, logic [1:0] m, logic [7:0] s);
    logic [VW-1:0] r;
    for (int l = 0; l < 8; l++)
      r[l*64 +: 64] = model_lane(a[l*64 +: 64], b[l*64 +: 64], c[l*64 +: 64], m, s);
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] r;
    for (int w = 0; w < 16; w++) r[w*32 +: 32] = $urandom;
    return r;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: drive, then evaluate the handshakes of the coming edge
  task automatic step(bit v, logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c,
                      logic [1:0] m, logic [7:0] s, bit rdy, string tag, output bit took);
    @(negedge clk);
    in_valid = v; mul_a_i = a; mul_b_i = b; acc_i = c; mode_i = m; shamt_i = s;
    out_ready = rdy;
    #1;
    if (prev_stall)  // R11 held result
      check(out_valid && (res_o == prev_res), "R11", "stalled result changed", res_o, prev_res);
    if (full_rate)   // R10
      check(in_ready == 1'b1, "R10", "in_ready dropped at full rate", VW'(in_ready), VW'(1));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "result with nothing in flight", res_o, '0);
      end else begin
        logic [VW-1:0] e;
        int pc;
        string t;
        e = exp_q.pop_front(); pc = cyc_q.pop_front(); t = tag_q.pop_front();
        check(res_o == e, t, "lane data", res_o, e);
        if (lat_mode)  // R9
          check(cyc == pc + 4, "R9", "latency", VW'(cyc - pc), VW'(4));
      end
    end
    took = v && in_ready;
    if (took) begin
      exp_q.push_back(model_vec(a, b, c, m, s));
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
    end
    prev_stall = out_valid && !out_ready;
    prev_res   = res_o;
    cyc++;
  endtask

  task automatic op(logic [VW-1:0] a, logic [VW-1:0] b, logic [VW-1:0] c,
                    logic [1:0] m, logic [7:0] s, string tag);
    bit t;
    step(1'b1, a, b, c, m, s, 1'b1, tag, t);
  endtask

  task automatic idle(int n);
    bit t;
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 2'b00, 8'd0, 1'b1, "R11", t);
  endtask

  initial begin
    logic [VW-1:0] ones52, big;
    ones52 = {8{64'h000F_FFFF_FFFF_FFFF}};
    big    = {8{64'hFFFF_FFFF_FFFF_FFFF}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "reset outputs",
          VW'({out_valid, in_ready}), VW'(2'b01));

    lat_mode = 1'b1;
    // R4 low half, lane index in the accumulator
    op(ones52, ones52, {64'd7,64'd6,64'd5,64'd4,64'd3,64'd2,64'd1,64'd0}, 2'b00, 8'd0, "R4");
    idle(5);
    // R3 upper operand bits set: only 3*5 may be added
    op({8{64'hFFF0_0000_0000_0003}}, {8{64'hABC0_0000_0000_0005}}, '0, 2'b00, 8'd0, "R3");
    op({8{64'hFFFF_0000_0000_0000}}, big, {8{64'd9}}, 2'b01, 8'd0, "R3");
    // R5 high half
    op(ones52, ones52, {8{64'd100}}, 2'b01, 8'd0, "R5");
    // R7 shift of zero on the same operands
    op(ones52, ones52, {8{64'd100}}, 2'b10, 8'd0, "R7");
    // R6 shifted high half
    op(rnd_vec(), rnd_vec(), rnd_vec(), 2'b10, 8'd5, "R6");
    // R8 bits pushed past bit 63, then shifts that leave nothing
    op(ones52, ones52, '0, 2'b10, 8'd20, "R8");
    op(ones52, ones52, {8{64'h1234_5678_9ABC_DEF0}}, 2'b10, 8'd64, "R8");
    op(ones52, ones52, {8{64'h0FED_CBA9_8765_4321}}, 2'b10, 8'd200, "R8");
    // R2 wrap to zero in every lane, then distinct random lanes
    op({8{64'd1}}, {8{64'd1}}, big, 2'b00, 8'd0, "R2");
    op(rnd_vec(), rnd_vec(), big, 2'b01, 8'd0, "R2");
    // R12 mode 3 as shifted mode
    op(rnd_vec(), rnd_vec(), rnd_vec(), 2'b11, 8'd7, "R12");
    idle(6);

    // R10 back-to-back random stream
    full_rate = 1'b1;
    for (int i = 0; i < 300; i++)
      op(rnd_vec(), rnd_vec(), rnd_vec(), 2'($urandom), 8'($urandom % 80), "R2");
    full_rate = 1'b0;
    idle(6);
    lat_mode = 1'b0;

    // R11 random gaps and back-pressure; payload held until taken
    for (int i = 0; i < 400; i++) begin
      logic [VW-1:0] a, b, c;
      logic [1:0] m;
      logic [7:0] s;
      bit took;
      a = rnd_vec(); b = rnd_vec(); c = rnd_vec(); m = 2'($urandom); s = 8'($urandom % 70);
      took = 1'b0;
      while (!took) begin
        if ($urandom % 4 == 0)
          step(1'b0, a, b, c, m, s, ($urandom % 3) != 0, "R11", took);
        else
          step(1'b1, a, b, c, m, s, ($urandom % 3) != 0, "R11", took);
      end
    end
    idle(10);
    check(exp_q.size() == 0, "R11", "results left undelivered", VW'(exp_q.size()), '0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule